// File: doc/BRIEF.md
# Bayer Bilinear Demosaic Engine

This engine rebuilds a full-colour image from a raster stream of 8-bit Bayer samples. The default image is 128 by 128. The engine does not hold the image itself. It drives three external single-port channel memories (red, green, blue). Each memory has a registered address, a write enable and write data, and it returns read data combinationally from the registered address, so read data arrives one cycle after the controller issues the address.

Operation has two phases. In the loading phase, every accepted sample is stored in the memory of its own colour site at its own pixel index. In the interpolation phase, a controller visits every interior pixel in raster order. For each pixel it fetches the neighbours it needs from the other two memories and sums them in 10-bit accumulators. It then writes the two missing channel values back at the pixel's own index. Border pixels keep only the sample they were loaded with. A done flag marks the end of the pass.

The pixel index is row times width plus column: the row sits in the upper bits and the column in the lower bits. The colour-site code is {row bit 0, column bit 0}. This code picks the neighbour pattern, the number of fetches (two or four) and the divide shift (1 or 2).

Top module: `bayer_demosaic`

## Requirements
- R1: While reset is high, and after it is released, done is low and all three write enables are low. The engine waits for load samples.
- R2: In loading, a sample accepted at index a is written only to its site's memory at index a. The site code {a[7], a[0]} selects the memory: 00 or 11 green, 01 red, 10 blue.
- R3: Loading ends once index 16383 (W*H-1) has been taken. The first interpolated pixel is row 1, column 1, which is index W+1 (129).
- R4: At site 00, red is floor((left+right)/2) and blue is floor((above+below)/2).
- R5: At site 11, blue is floor((left+right)/2) and red is floor((above+below)/2).
- R6: At site 01 (red), green is floor of the sum of the four orthogonal neighbours divided by 4, and blue is the same over the four diagonal neighbours. Four samples of 255 give exactly 255.
- R7: At site 10 (blue), green comes from the four orthogonal neighbours and red from the four diagonal neighbours, each divided by 4.
- R8: A write-back writes exactly the two missing channels, at the centre index. A pixel's own channel value and every border entry of the missing channels are left unchanged.
- R9: Interior pixels are written back in raster order. After column W-2 the next pixel is column 1 of the next row, and no border pixel is ever visited.
- R10: done rises after the write-back of pixel (H-2, W-2). It stays high until reset, and no write occurs after it.
- R11: Accumulators are cleared before each pixel, so each result depends only on that pixel's neighbours.
- R12: A cycle with in_en low during loading writes nothing and does not advance the load index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| in_en | input | 1 | Input sample valid |
| data_in | input | 8 | Bayer sample |
| addr_r_o | output | 14 | Red memory address |
| wr_r_o | output | 1 | Red memory write enable |
| wdata_r_o | output | 8 | Red memory write data |
| rdata_r_i | input | 8 | Red memory read data |
| addr_g_o | output | 14 | Green memory address |
| wr_g_o | output | 1 | Green memory write enable |
| wdata_g_o | output | 8 | Green memory write data |
| rdata_g_i | input | 8 | Green memory read data |
| addr_b_o | output | 14 | Blue memory address |
| wr_b_o | output | 1 | Blue memory write enable |
| wdata_b_o | output | 8 | Blue memory write data |
| rdata_b_i | input | 8 | Blue memory read data |
| done | output | 1 | Pass complete, held until reset |

## Verification
The assertions check the following on every cycle:
- a load cycle raises at most one write enable;
- every write-back raises exactly two enables at the centre index;
- fetching happens only on interior pixels and within the fetch count;
- accumulators are empty after a clear;
- done holds and no write follows it.

The arithmetic of each site pattern, the raster order with its row skip, the load gaps and the untouched border and own-channel entries can only be shown by the bench. It compares every write against a queued model and checks the final memory contents, over a mixed-value frame and a saturated all-255 frame.

// File: rtl/bayer_demosaic_pkg.sv
package bayer_demosaic_pkg;

   localparam int NUM_CH = 3;
   localparam int CH_R   = 0;
   localparam int CH_G   = 1;
   localparam int CH_B   = 2;

   typedef enum logic [2:0] {
      ST_LOAD  = 3'd0,
      ST_SEED  = 3'd1,
      ST_CLEAR = 3'd2,
      ST_FETCH = 3'd3,
      ST_WRITE = 3'd4,
      ST_DONE  = 3'd5
   } dm_state_e;

   // site code = {row bit 0, column bit 0}
   typedef enum logic [1:0] {
      SITE_G_EVEN = 2'b00,
      SITE_RED    = 2'b01,
      SITE_BLUE   = 2'b10,
      SITE_G_ODD  = 2'b11
   } site_e;

   // one-hot channel that a site carries natively (bit index = channel)
   function automatic logic [NUM_CH-1:0] own_mask(site_e s);
      case (s)
         SITE_RED:  own_mask = 3'b001;
         SITE_BLUE: own_mask = 3'b100;
         default:   own_mask = 3'b010;
      endcase
   endfunction

   function automatic logic is_green(site_e s);
      is_green = (s == SITE_G_EVEN) || (s == SITE_G_ODD);
   endfunction

endpackage

// File: rtl/bdm_nbr_addr.sv
module bdm_nbr_addr
   import bayer_demosaic_pkg::*;
#(
   parameter int COL_BITS = 7,
   parameter int ROW_BITS = 7,
   localparam int ADDR_W  = COL_BITS + ROW_BITS
) (
   input  logic [ADDR_W-1:0]             center,
   input  site_e                         site,
   input  logic [1:0]                    step,
   output logic [NUM_CH-1:0][ADDR_W-1:0] rd_addr,
   output logic [NUM_CH-1:0]             rd_mask
);

   logic [ROW_BITS-1:0] row, row_up, row_dn;
   logic [COL_BITS-1:0] col, col_lf, col_rt;
   logic [ADDR_W-1:0]   horiz, vert, orth, diag;

   assign row    = center[ADDR_W-1:COL_BITS];
   assign col    = center[COL_BITS-1:0];
   assign row_up = row - 1'b1;
   assign row_dn = row + 1'b1;
   assign col_lf = col - 1'b1;
   assign col_rt = col + 1'b1;

   // two-point pairs: step 0 takes the first member, step 1 the second
   assign horiz = step[0] ? {row, col_rt} : {row, col_lf};
   assign vert  = step[0] ? {row_dn, col} : {row_up, col};

   always_comb begin
      case (step)
         2'd0:    orth = {row, col_lf};
         2'd1:    orth = {row, col_rt};
         2'd2:    orth = {row_up, col};
         default: orth = {row_dn, col};
      endcase
      case (step)
         2'd0:    diag = {row_up, col_lf};
         2'd1:    diag = {row_up, col_rt};
         2'd2:    diag = {row_dn, col_lf};
         default: diag = {row_dn, col_rt};
      endcase
   end

   always_comb begin
      rd_addr = '{default: center};
      rd_mask = '0;
      case (site)
         SITE_G_EVEN: begin
            rd_addr[CH_R] = horiz;  rd_addr[CH_B] = vert;
            rd_mask[CH_R] = 1'b1;   rd_mask[CH_B] = 1'b1;
         end
         SITE_G_ODD: begin
            rd_addr[CH_B] = horiz;  rd_addr[CH_R] = vert;
            rd_mask[CH_R] = 1'b1;   rd_mask[CH_B] = 1'b1;
         end
         SITE_RED: begin
            rd_addr[CH_G] = orth;   rd_addr[CH_B] = diag;
            rd_mask[CH_G] = 1'b1;   rd_mask[CH_B] = 1'b1;
         end
         default: begin
            rd_addr[CH_G] = orth;   rd_addr[CH_R] = diag;
            rd_mask[CH_G] = 1'b1;   rd_mask[CH_R] = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/bdm_chan_acc.sv
module bdm_chan_acc #(
   parameter int PIX_W   = 8,
   localparam int ACC_W  = PIX_W + 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             en,
   input  logic [PIX_W-1:0] din,
   input  logic             shift2,
   output logic [PIX_W-1:0] avg
);

   localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'(4 * ((1 << PIX_W) - 1));

   logic [ACC_W-1:0] acc;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)      acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= acc + ACC_W'(din);
   end

   assign avg = shift2 ? acc[PIX_W+1:2] : acc[PIX_W:1];

   assert_acc_cleared_R11: assert property (@(posedge clk) disable iff (rst)
      clr |=> (acc == '0));

   assert_acc_in_range_R6: assert property (@(posedge clk) disable iff (rst)
      acc <= ACC_MAX);

endmodule

// File: rtl/bayer_demosaic.sv
module bayer_demosaic
   import bayer_demosaic_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int COL_BITS = 7,
   parameter int ROW_BITS = 7,
   localparam int ADDR_W  = COL_BITS + ROW_BITS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_en,
   input  logic [PIX_W-1:0]  data_in,
   output logic [ADDR_W-1:0] addr_r_o,
   output logic              wr_r_o,
   output logic [PIX_W-1:0]  wdata_r_o,
   input  logic [PIX_W-1:0]  rdata_r_i,
   output logic [ADDR_W-1:0] addr_g_o,
   output logic              wr_g_o,
   output logic [PIX_W-1:0]  wdata_g_o,
   input  logic [PIX_W-1:0]  rdata_g_i,
   output logic [ADDR_W-1:0] addr_b_o,
   output logic              wr_b_o,
   output logic [PIX_W-1:0]  wdata_b_o,
   input  logic [PIX_W-1:0]  rdata_b_i,
   output logic              done
);

   localparam int IMG_W = 1 << COL_BITS;
   localparam int IMG_H = 1 << ROW_BITS;
   localparam logic [ADDR_W-1:0]   LAST_ADDR = '1;
   localparam logic [ADDR_W-1:0]   FIRST_INT = ADDR_W'(IMG_W + 1);
   localparam logic [ADDR_W-1:0]   LAST_INT  = ADDR_W'((IMG_H - 2) * IMG_W + IMG_W - 2);
   localparam logic [COL_BITS-1:0] LAST_COL  = COL_BITS'(IMG_W - 2);
   localparam logic [ROW_BITS-1:0] LAST_ROW  = ROW_BITS'(IMG_H - 2);

   generate
      if (COL_BITS < 2 || ROW_BITS < 2) begin : g_bad_geom
         $error("bayer_demosaic: image must be at least 4 by 4");
      end
      if (PIX_W < 1) begin : g_bad_pix
         $error("bayer_demosaic: PIX_W must be positive");
      end
   endgenerate

   dm_state_e         state;
   logic [ADDR_W-1:0] center;
   logic [2:0]        step_cnt;
   logic              last_px;
   logic              done_q;

   logic [NUM_CH-1:0]             wr_q;
   logic [NUM_CH-1:0][ADDR_W-1:0] addr_q;
   logic [NUM_CH-1:0][PIX_W-1:0]  wdata_q;
   logic [NUM_CH-1:0][PIX_W-1:0]  rdata_arr;
   logic [NUM_CH-1:0][PIX_W-1:0]  avg_arr;
   logic [NUM_CH-1:0][ADDR_W-1:0] nbr_addr;
   logic [NUM_CH-1:0]             nbr_mask;

   site_e         site;
   logic [2:0]    nbr_total;
   logic          acc_clr;
   logic          acc_step;
   logic [COL_BITS-1:0] col;
   logic [ROW_BITS-1:0] row;

   assign site      = site_e'({center[COL_BITS], center[0]});
   assign nbr_total = is_green(site) ? 3'd2 : 3'd4;
   assign col       = center[COL_BITS-1:0];
   assign row       = center[ADDR_W-1:COL_BITS];

   assign rdata_arr[CH_R] = rdata_r_i;
   assign rdata_arr[CH_G] = rdata_g_i;
   assign rdata_arr[CH_B] = rdata_b_i;

   bdm_nbr_addr #(
      .COL_BITS (COL_BITS),
      .ROW_BITS (ROW_BITS)
   ) nbr_i (
      .center  (center),
      .site    (site),
      .step    (step_cnt[1:0]),
      .rd_addr (nbr_addr),
      .rd_mask (nbr_mask)
   );

   // a fetch cycle after the first one consumes the data addressed one cycle earlier
   assign acc_clr  = (state == ST_CLEAR);
   assign acc_step = (state == ST_FETCH) && (step_cnt != 3'd0);

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_acc
         bdm_chan_acc #(
            .PIX_W (PIX_W)
         ) acc_i (
            .clk    (clk),
            .rst    (rst),
            .clr    (acc_clr),
            .en     (acc_step && nbr_mask[ch]),
            .din    (rdata_arr[ch]),
            .shift2 (!is_green(site)),
            .avg    (avg_arr[ch])
         );
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state    <= ST_LOAD;
         center   <= '0;
         step_cnt <= '0;
         last_px  <= 1'b0;
         done_q   <= 1'b0;
         wr_q     <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
      end else begin
         case (state)
            ST_LOAD: begin
               wr_q <= '0;
               if (in_en) begin
                  center  <= center + 1'b1;
                  addr_q  <= '{default: center};
                  wdata_q <= '{default: data_in};
                  wr_q    <= own_mask(site);
                  if (center == LAST_ADDR) state <= ST_SEED;
               end
            end
            ST_SEED: begin
               wr_q   <= '0;
               center <= FIRST_INT;
               state  <= ST_CLEAR;
            end
            ST_CLEAR: begin
               wr_q     <= '0;
               step_cnt <= '0;
               if (last_px) begin
                  state  <= ST_DONE;
                  done_q <= 1'b1;
               end else begin
                  state <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               step_cnt <= step_cnt + 1'b1;
               if (step_cnt < nbr_total) begin
                  for (int ch = 0; ch < NUM_CH; ch++) begin
                     if (nbr_mask[ch]) addr_q[ch] <= nbr_addr[ch];
                  end
               end else begin
                  state <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               addr_q  <= '{default: center};
               wdata_q <= avg_arr;
               wr_q    <= ~own_mask(site);
               last_px <= (center == LAST_INT);
               center  <= (col == LAST_COL) ? center + ADDR_W'(3) : center + 1'b1;
               state   <= ST_CLEAR;
            end
            default: begin
               wr_q <= '0;
            end
         endcase
      end
   end

   assign addr_r_o  = addr_q[CH_R];
   assign addr_g_o  = addr_q[CH_G];
   assign addr_b_o  = addr_q[CH_B];
   assign wr_r_o    = wr_q[CH_R];
   assign wr_g_o    = wr_q[CH_G];
   assign wr_b_o    = wr_q[CH_B];
   assign wdata_r_o = wdata_q[CH_R];
   assign wdata_g_o = wdata_q[CH_G];
   assign wdata_b_o = wdata_q[CH_B];
   assign done      = done_q;

   assert_load_single_wr_R2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_LOAD) |=> $onehot0({wr_r_o, wr_g_o, wr_b_o}));

   assert_wb_two_channels_R8: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WRITE) |=> ($countones({wr_r_o, wr_g_o, wr_b_o}) == 2));

   assert_wb_at_center_R8: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WRITE) |=> (addr_g_o == $past(center) && addr_r_o == $past(center)));

   assert_fetch_interior_R9: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |-> (col != '0 && col <= LAST_COL && row != '0 && row <= LAST_ROW));

   assert_fetch_count_R6: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |-> (step_cnt <= 3'd4));

   assert_done_held_R10: assert property (@(posedge clk) disable iff (rst)
      done |=> done);

   assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DONE) |-> ({wr_r_o, wr_g_o, wr_b_o} == 3'b000));

endmodule

// File: tb/bayer_demosaic_tb_top.sv
module bayer_demosaic_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CB   = 4;
   localparam int RB   = 4;
   localparam int AW   = CB + RB;
   localparam int W    = 1 << CB;
   localparam int H    = 1 << RB;
   localparam int NPIX = W * H;
   localparam int SENT = 8'hA5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_en = 1'b0;
   logic [7:0] data_in = '0;
   logic [AW-1:0] addr_r, addr_g, addr_b;
   logic wr_r, wr_g, wr_b, done;
   logic [7:0] wdata_r, wdata_g, wdata_b, rdata_r, rdata_g, rdata_b;

   logic [7:0] mem_r [NPIX];
   logic [7:0] mem_g [NPIX];
   logic [7:0] mem_b [NPIX];
   logic init_req = 1'b0;
   logic loading = 1'b0;
   logic ld_q = 1'b0;
   logic en_q = 1'b0;

   typedef struct {int addr; int data; int tag;} exp_t;
   exp_t q_r[$];
   exp_t q_g[$];
   exp_t q_b[$];
   int img [NPIX];
   int exp_mem [3][NPIX];
   int tests = 0;
   int fails = 0;
   bit seen_interp = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bayer_demosaic #(.PIX_W(8), .COL_BITS(CB), .ROW_BITS(RB)) dut_i (
      .clk(clk), .rst(rst), .in_en(in_en), .data_in(data_in),
      .addr_r_o(addr_r), .wr_r_o(wr_r), .wdata_r_o(wdata_r), .rdata_r_i(rdata_r),
      .addr_g_o(addr_g), .wr_g_o(wr_g), .wdata_g_o(wdata_g), .rdata_g_i(rdata_g),
      .addr_b_o(addr_b), .wr_b_o(wr_b), .wdata_b_o(wdata_b), .rdata_b_i(rdata_b),
      .done(done)
   );

   // behavioural channel memories: registered write, read straight from the address
   always @(posedge clk) begin
      if (init_req) begin
         for (int i = 0; i < NPIX; i++) begin
            mem_r[i] <= 8'(SENT); mem_g[i] <= 8'(SENT); mem_b[i] <= 8'(SENT);
         end
      end else begin
         if (wr_r) mem_r[addr_r] <= wdata_r;
         if (wr_g) mem_g[addr_g] <= wdata_g;
         if (wr_b) mem_b[addr_b] <= wdata_b;
      end
   end
   assign rdata_r = mem_r[addr_r];
   assign rdata_g = mem_g[addr_g];
   assign rdata_b = mem_b[addr_b];

   always @(posedge clk) begin
      en_q <= in_en;
      ld_q <= loading;
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic string tag_name(input int t);
      case (t)
         2: return "R2";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic int px(input int r, input int c);
      return img[r * W + c];
   endfunction

   function automatic int own_ch(input int a);
      int code = (((a >> CB) & 1) << 1) | (a & 1);
      if (code == 1) return 0;
      if (code == 2) return 2;
      return 1;
   endfunction

   task automatic push(input int ch, input int a, input int d, input int t);
      exp_t e;
      e.addr = a; e.data = d; e.tag = t;
      exp_mem[ch][a] = d;
      case (ch)
         0: q_r.push_back(e);
         1: q_g.push_back(e);
         default: q_b.push_back(e);
      endcase
   endtask

   task automatic build_expect();
      q_r.delete(); q_g.delete(); q_b.delete();
      for (int a = 0; a < NPIX; a++) begin
         for (int ch = 0; ch < 3; ch++) exp_mem[ch][a] = SENT;
      end
      for (int a = 0; a < NPIX; a++) push(own_ch(a), a, img[a], 2);
      for (int r = 1; r < H - 1; r++) begin
         for (int c = 1; c < W - 1; c++) begin
            int code = ((r & 1) << 1) | (c & 1);
            int hz = (px(r, c-1) + px(r, c+1)) >> 1;
            int vt = (px(r-1, c) + px(r+1, c)) >> 1;
            int ot = (px(r, c-1) + px(r, c+1) + px(r-1, c) + px(r+1, c)) >> 2;
            int dg = (px(r-1, c-1) + px(r-1, c+1) + px(r+1, c-1) + px(r+1, c+1)) >> 2;
            int a = r * W + c;
            case (code)
               0: begin push(0, a, hz, 4); push(2, a, vt, 4); end
               3: begin push(2, a, hz, 5); push(0, a, vt, 5); end
               1: begin push(1, a, ot, 6); push(2, a, dg, 6); end
               default: begin push(1, a, ot, 7); push(0, a, dg, 7); end
            endcase
         end
      end
   endtask

   // compares one observed write with the head of that channel's queue
   task automatic take(input int ch, input int a, input int d);
      exp_t e;
      int sz = (ch == 0) ? q_r.size() : (ch == 1) ? q_g.size() : q_b.size();
      if (sz == 0) begin
         check("R10", "write with nothing expected", 1, 0);
         return;
      end
      case (ch)
         0: e = q_r.pop_front();
         1: e = q_g.pop_front();
         default: e = q_b.pop_front();
      endcase
      if (e.tag != 2 && !seen_interp) begin
         seen_interp = 1;
         check("R3", "first interpolated index", a, W + 1);
      end
      check((e.tag == 2) ? "R2" : "R9", "write index", a, e.addr);
      // R11: a stale accumulator would corrupt every later value checked here
      check(tag_name(e.tag), "write data", d, e.data);
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         if (ld_q && !en_q) check("R12", "write during idle load cycle", {wr_r, wr_g, wr_b}, 0);
         if (wr_r) take(0, int'(addr_r), int'(wdata_r));
         if (wr_g) take(1, int'(addr_g), int'(wdata_g));
         if (wr_b) take(2, int'(addr_b), int'(wdata_b));
      end
   end

   task automatic run_frame(input int kind);
      int cyc;
      for (int a = 0; a < NPIX; a++) begin
         if (kind == 0) begin
            img[a] = ((a * 73 + 29) ^ (a >> 3)) & 255;
            if (a % 7 == 3) img[a] = 255;
            if (a % 11 == 5) img[a] = 0;
         end else begin
            img[a] = 255;
         end
      end
      build_expect();
      rst = 1'b1;
      init_req = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "done in reset", int'(done), 0);
      check("R1", "write enables in reset", {wr_r, wr_g, wr_b}, 0);
      init_req = 1'b0;
      rst = 1'b0;
      seen_interp = 0;
      @(negedge clk);
      check("R1", "write enables after reset", {wr_r, wr_g, wr_b}, 0);
      loading = 1'b1;
      for (int a = 0; a < NPIX; a++) begin
         if (a % 23 == 5) begin
            in_en = 1'b0;
            repeat (2) @(negedge clk);
         end
         in_en = 1'b1;
         data_in = 8'(img[a]);
         @(negedge clk);
      end
      in_en = 1'b0;
      loading = 1'b0;
      cyc = 0;
      while (!done && cyc < 40000) begin
         @(negedge clk);
         cyc++;
      end
      check("R10", "done reached", int'(done), 1);
      check("R10", "expected writes left at done", q_r.size() + q_g.size() + q_b.size(), 0);
      for (int i = 0; i < 20; i++) begin
         in_en = (i % 2 == 0);
         @(negedge clk);
         check("R10", "done held", int'(done), 1);
      end
      in_en = 1'b0;
      for (int a = 0; a < NPIX; a++) begin
         check("R8", "red memory", int'(mem_r[a]), exp_mem[0][a]);
         check("R8", "green memory", int'(mem_g[a]), exp_mem[1][a]);
         check("R8", "blue memory", int'(mem_b[a]), exp_mem[2][a]);
      end
   endtask

   initial begin
      run_frame(0);
      run_frame(1);   // R6 R7 saturated neighbours exercise the 10-bit sum
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      tests++;
      $display("FAIL R10 watchdog expired: actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule